// File: doc/BRIEF.md
# Short-descriptor region attribute decoder

This block turns the memory-type bits of a short-format page descriptor into a set of orthogonal memory attributes. The inputs are a 3-bit type-extension field, a cacheable bit, a bufferable bit and a shareable bit. The outputs are the memory kind, the device subtype, the cacheability class and allocation hint for the inner and outer levels, the two shareability flags, and a flag for encodings whose meaning the implementation chooses. A translation pipeline presents one descriptor per cycle on a valid strobe. The registered attribute set comes back one clock later.

Two decode schemes are available, chosen by `remap_en`. In the direct scheme, the five type bits are decoded in a fixed way. In the remap scheme, the low type-extension bit and the two cache bits form a 3-bit region number. That number selects a 2-bit region kind from a 32-bit primary remap word and two 2-bit cacheability codes from a 32-bit normal-memory remap word. In the remap scheme, the share bit comes from one of two primary-word bits, chosen by the shareable input. Encodings that have no defined meaning are replaced by Device-nGnRnE.

Top module: `sda_attr_decoder`

## Requirements
- R1: While `rst_n` is low, `out_valid` and every attribute output are 0.
- R2: A descriptor presented with `in_valid`=1 at a rising edge appears on the attribute outputs after that edge, with `out_valid`=1. After an edge with `in_valid`=0, `out_valid` is 0 and every attribute output keeps its previous value, whatever the other inputs are.
- R3: In the direct scheme, code {tex,c,b}=00000 gives Device with device kind 00 (nGnRnE). Codes 00001 and 01000 give Device with kind 01 (nGnRE). Every Device or implementation-defined result has `out_normal`=0, and all of its cacheability, hint and share outputs are 0.
- R4: The 2-bit cacheability codes convert to an {attr,hint} pair as follows: 00 gives {00 Non-cacheable, 00 no allocation}, 01 gives {11 Write-back, 11 read+write allocate}, 10 gives {10 Write-through, 10 read allocate}, and 11 gives {11 Write-back, 10 read allocate}. In the direct scheme, codes 00010, 00011 and 00100 give Normal (`out_normal`=1), with both levels converted from {c,b}.
- R5: In the direct scheme, code 00111 gives Normal with both levels set to Write-back read+write allocate. Any code with tex[2]=1 gives Normal, with the inner level converted from {c,b} and the outer level converted from tex[1:0].
- R6: Code 00110 in the direct scheme, and region 6 in the remap scheme, set `out_impl`=1 with `out_normal`=0 and kind 00. Every other result has `out_impl`=0.
- R7: In the direct scheme, the reserved codes decode as 00000 (Device-nGnRnE). The reserved codes are: tex=001 with {c,b}=01, tex=010 with {c,b}≠00, and tex=011.
- R8: For a Normal result in the direct scheme, `out_share` equals the shareable input and `out_oshare` equals `out_share`.
- R9: In the remap scheme, the region number is r={tex[0],c,b}, and tex[2:1] has no effect. The region kind is prim bits [2r+1:2r]: 00 gives Device nGnRnE, 01 gives Device nGnRE, and 10 gives Normal.
- R10: In the remap scheme, region kind 11 decodes as Device-nGnRnE.
- R11: For a Normal region, the inner level is converted from norm bits [2r+1:2r] and the outer level from norm bits [2r+17:2r+16].
- R12: For a Normal region, the share bit is prim bit 18 when the shareable input is 0, and prim bit 19 when it is 1. `out_share` is that share bit. `out_oshare` is the share bit ANDed with the inverse of prim bit 24+r.
- R13: `out_transient` and `out_tagged` are 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Descriptor bits are valid this cycle |
| remap_en | input | 1 | 1 selects the remap scheme, 0 the direct scheme |
| tex | input | 3 | Type-extension field |
| cache_b | input | 1 | Cacheable bit |
| buf_b | input | 1 | Bufferable bit |
| share_b | input | 1 | Shareable bit |
| prim_remap | input | 32 | Primary remap word (region kinds, share select bits, outer-share disables) |
| norm_remap | input | 32 | Normal-memory remap word (inner codes in bits 15:0, outer codes in bits 31:16) |
| out_valid | output | 1 | Attribute outputs were loaded at the last edge |
| out_normal | output | 1 | 1 Normal memory, 0 Device |
| out_dev_kind | output | 2 | Device subtype: 00 nGnRnE, 01 nGnRE |
| out_in_attr | output | 2 | Inner cacheability: 00 NC, 10 WT, 11 WB |
| out_in_hint | output | 2 | Inner allocation hint: 00 none, 10 read, 11 read+write |
| out_out_attr | output | 2 | Outer cacheability, same encoding |
| out_out_hint | output | 2 | Outer allocation hint, same encoding |
| out_share | output | 1 | Shareable |
| out_oshare | output | 1 | Outer-shareable |
| out_impl | output | 1 | Implementation-defined encoding seen |
| out_transient | output | 1 | Transient hint, held 0 |
| out_tagged | output | 1 | Tagged memory, held 0 |

## Verification
The only internal state is the registered attribute word and its valid bit. A wrong next-state selection therefore shows at the ports on the edge right after the descriptor that caused it. If a slice in the remap scheme is misindexed, the fault shows only for the region that reads it. For that reason every region number is swept against several remap words, with both values of the shareable input. A failure to hold the outputs shows on the first idle cycle, when the inputs are scrambled while `in_valid` is low.

// File: rtl/sda_pkg.sv
package sda_pkg;

  localparam int REGION_W  = 3;
  localparam int NREGIONS  = 1 << REGION_W;
  localparam int REMAP_W   = 32;
  localparam int OUTER_OFS = 16;
  localparam int SEL0_BIT  = 18;
  localparam int SEL1_BIT  = 19;
  localparam int OSH_BASE  = 24;
  localparam int IMPL_REGION = 6;

  localparam logic [1:0] CA_NC = 2'b00;
  localparam logic [1:0] CA_WT = 2'b10;
  localparam logic [1:0] CA_WB = 2'b11;
  localparam logic [1:0] HN_NONE = 2'b00;
  localparam logic [1:0] HN_RA   = 2'b10;
  localparam logic [1:0] HN_RWA  = 2'b11;
  localparam logic [1:0] DEV_NGNRNE = 2'b00;
  localparam logic [1:0] DEV_NGNRE  = 2'b01;

  typedef struct packed {
    logic       normal;
    logic [1:0] dev;
    logic [1:0] in_attr;
    logic [1:0] in_hint;
    logic [1:0] out_attr;
    logic [1:0] out_hint;
    logic       shr;
    logic       oshr;
    logic       impl;
  } attr_t;

  // Converts a 2-bit cacheability code into {attr, hint}.
  function automatic logic [3:0] conv_code(input logic [1:0] code);
    logic [3:0] r;
    case (code)
      2'b00:   r = {CA_NC, HN_NONE};
      2'b01:   r = {CA_WB, HN_RWA};
      2'b10:   r = {CA_WT, HN_RA};
      default: r = {CA_WB, HN_RA};
    endcase
    return r;
  endfunction

  function automatic attr_t device_attr(input logic [1:0] kind);
    attr_t a;
    a     = '0;
    a.dev = kind;
    return a;
  endfunction

  function automatic attr_t impl_attr();
    attr_t a;
    a      = '0;
    a.impl = 1'b1;
    return a;
  endfunction

  function automatic attr_t normal_attr(input logic [1:0] inner_code,
                                        input logic [1:0] outer_code,
                                        input logic shr, input logic oshr);
    attr_t a;
    a        = '0;
    a.normal = 1'b1;
    {a.in_attr, a.in_hint}   = conv_code(inner_code);
    {a.out_attr, a.out_hint} = conv_code(outer_code);
    a.shr    = shr;
    a.oshr   = oshr;
    return a;
  endfunction

endpackage

// File: rtl/sda_default_dec.sv
module sda_default_dec
  import sda_pkg::*;
(
  input  logic [2:0] tex,
  input  logic       cache_b,
  input  logic       buf_b,
  input  logic       share_b,
  output attr_t      res
);

  logic       reserved;
  logic [4:0] code;

  always_comb begin
    reserved = ((tex == 3'b001) && ({cache_b, buf_b} == 2'b01)) ||
               ((tex == 3'b010) && ({cache_b, buf_b} != 2'b00)) ||
               (tex == 3'b011);
    code = reserved ? 5'b00000 : {tex, cache_b, buf_b};
  end

  always_comb begin
    res = '0;
    if (code[4]) begin
      res = normal_attr(code[1:0], code[3:2], share_b, share_b);
    end else begin
      case (code[3:0])
        4'b0000:                   res = device_attr(DEV_NGNRNE);
        4'b0001, 4'b1000:          res = device_attr(DEV_NGNRE);
        4'b0010, 4'b0011, 4'b0100: res = normal_attr(code[1:0], code[1:0], share_b, share_b);
        4'b0110:                   res = impl_attr();
        4'b0111:                   res = normal_attr(2'b01, 2'b01, share_b, share_b);
        default:                   res = device_attr(DEV_NGNRNE);
      endcase
    end
  end

endmodule

// File: rtl/sda_remap_dec.sv
module sda_remap_dec
  import sda_pkg::*;
(
  input  logic [REGION_W-1:0] region,
  input  logic                share_b,
  input  logic [REMAP_W-1:0]  prim_remap,
  input  logic [REMAP_W-1:0]  norm_remap,
  output attr_t               res
);

  logic [1:0] kind_r  [NREGIONS];
  logic [1:0] inner_r [NREGIONS];
  logic [1:0] outer_r [NREGIONS];
  logic       osh_dis [NREGIONS];

  for (genvar r = 0; r < NREGIONS; r++) begin : g_slice
    assign kind_r[r]  = prim_remap[2*r+1 : 2*r];
    assign inner_r[r] = norm_remap[2*r+1 : 2*r];
    assign outer_r[r] = norm_remap[OUTER_OFS+2*r+1 : OUTER_OFS+2*r];
    assign osh_dis[r] = prim_remap[OSH_BASE+r];
  end

  logic [1:0] kind;
  logic       sbit;

  always_comb begin
    kind = kind_r[region];
    if (kind == 2'b11) kind = 2'b00;
    sbit = share_b ? prim_remap[SEL1_BIT] : prim_remap[SEL0_BIT];
    res  = '0;
    if (region == REGION_W'(IMPL_REGION)) begin
      res = impl_attr();
    end else begin
      case (kind)
        2'b01:   res = device_attr(DEV_NGNRE);
        2'b10:   res = normal_attr(inner_r[region], outer_r[region],
                                   sbit, sbit & ~osh_dis[region]);
        default: res = device_attr(DEV_NGNRNE);
      endcase
    end
  end

endmodule

// File: rtl/sda_attr_decoder.sv
module sda_attr_decoder
  import sda_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        remap_en,
  input  logic [2:0]  tex,
  input  logic        cache_b,
  input  logic        buf_b,
  input  logic        share_b,
  input  logic [31:0] prim_remap,
  input  logic [31:0] norm_remap,
  output logic        out_valid,
  output logic        out_normal,
  output logic [1:0]  out_dev_kind,
  output logic [1:0]  out_in_attr,
  output logic [1:0]  out_in_hint,
  output logic [1:0]  out_out_attr,
  output logic [1:0]  out_out_hint,
  output logic        out_share,
  output logic        out_oshare,
  output logic        out_impl,
  output logic        out_transient,
  output logic        out_tagged
);

  attr_t df_res, rm_res, res_d, res_q;
  logic  vld_q;

  sda_default_dec u_default (
    .tex     (tex),
    .cache_b (cache_b),
    .buf_b   (buf_b),
    .share_b (share_b),
    .res     (df_res)
  );

  sda_remap_dec u_remap (
    .region     ({tex[0], cache_b, buf_b}),
    .share_b    (share_b),
    .prim_remap (prim_remap),
    .norm_remap (norm_remap),
    .res        (rm_res)
  );

  // Next-state with explicit load enable.
  always_comb begin
    res_d = res_q;
    if (in_valid) res_d = remap_en ? rm_res : df_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= in_valid;
    end
  end

  assign out_valid     = vld_q;
  assign out_normal    = res_q.normal;
  assign out_dev_kind  = res_q.dev;
  assign out_in_attr   = res_q.in_attr;
  assign out_in_hint   = res_q.in_hint;
  assign out_out_attr  = res_q.out_attr;
  assign out_out_hint  = res_q.out_hint;
  assign out_share     = res_q.shr;
  assign out_oshare    = res_q.oshr;
  assign out_impl      = res_q.impl;
  assign out_transient = 1'b0;
  assign out_tagged    = 1'b0;

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(res_q)));

  // R3
  device_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_normal) |->
      (out_in_attr == 2'b00 && out_out_attr == 2'b00 && !out_share && !out_oshare));

  // R6
  impl_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_impl |-> (!out_normal && out_dev_kind == 2'b00));

  // R7
  dev_kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_normal) |-> !out_dev_kind[1]);

  // R12
  oshare_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_oshare |-> out_share);

endmodule

// File: tb/sda_attr_decoder_tb_top.sv
module sda_attr_decoder_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, remap_en, cache_b, buf_b, share_b;
  logic [2:0]  tex;
  logic [31:0] prim_remap, norm_remap;
  logic        out_valid, out_normal, out_share, out_oshare, out_impl;
  logic        out_transient, out_tagged;
  logic [1:0]  out_dev_kind, out_in_attr, out_in_hint, out_out_attr, out_out_hint;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sda_attr_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .remap_en(remap_en),
    .tex(tex), .cache_b(cache_b), .buf_b(buf_b), .share_b(share_b),
    .prim_remap(prim_remap), .norm_remap(norm_remap),
    .out_valid(out_valid), .out_normal(out_normal), .out_dev_kind(out_dev_kind),
    .out_in_attr(out_in_attr), .out_in_hint(out_in_hint),
    .out_out_attr(out_out_attr), .out_out_hint(out_out_hint),
    .out_share(out_share), .out_oshare(out_oshare), .out_impl(out_impl),
    .out_transient(out_transient), .out_tagged(out_tagged)
  );

  function automatic logic [15:0] observed();
    return {out_normal, out_dev_kind, out_in_attr, out_in_hint,
            out_out_attr, out_out_hint, out_share, out_oshare, out_impl,
            out_transient, out_tagged};
  endfunction

  function automatic logic [3:0] cv(input logic [1:0] x);
    case (x)
      2'b00:   return 4'b0000;
      2'b01:   return 4'b1111;
      2'b10:   return 4'b1010;
      default: return 4'b1110;
    endcase
  endfunction

  // Packs {normal, dev, inner, outer, share, oshare, impl, transient, tagged}.
  function automatic logic [15:0] pk_dev(input logic [1:0] k);
    return {1'b0, k, 13'b0};
  endfunction
  function automatic logic [15:0] pk_norm(input logic [1:0] ic, input logic [1:0] oc,
                                          input logic sh, input logic osh);
    return {1'b1, 2'b00, cv(ic), cv(oc), sh, osh, 3'b000};
  endfunction

  function automatic logic [15:0] model(input logic rm, input logic [2:0] t, input logic c,
                                        input logic b, input logic s, input logic [31:0] pr,
                                        input logic [31:0] nm, output string tag);
    logic [4:0] k;
    int r;
    logic [1:0] kind;
    logic sb;
    k = {t, c, b};
    if (!rm) begin
      if ((t == 3'b001 && {c,b} == 2'b01) || (t == 3'b010 && {c,b} != 2'b00) || t == 3'b011) begin
        tag = "R7 R13"; return pk_dev(2'b00);
      end
      if (t[2]) begin tag = "R5 R8 R13"; return pk_norm({c,b}, t[1:0], s, s); end
      if (k == 5'b00000) begin tag = "R3 R13"; return pk_dev(2'b00); end
      if (k == 5'b00001 || k == 5'b01000) begin tag = "R3 R13"; return pk_dev(2'b01); end
      if (k == 5'b00110) begin tag = "R6 R13"; return 16'h0004; end
      if (k == 5'b00111) begin tag = "R5 R8 R13"; return pk_norm(2'b01, 2'b01, s, s); end
      tag = "R4 R8 R13"; return pk_norm({c,b}, {c,b}, s, s);
    end
    r = int'({t[0], c, b});
    if (r == 6) begin tag = "R6 R9 R13"; return 16'h0004; end
    kind = pr[2*r +: 2];
    if (kind == 2'b11) begin tag = "R10 R13"; return pk_dev(2'b00); end
    if (kind != 2'b10) begin tag = "R9 R13"; return pk_dev(kind); end
    sb = s ? pr[19] : pr[18];
    tag = "R9 R11 R12 R13";
    return pk_norm(nm[2*r +: 2], nm[16+2*r +: 2], sb, sb & ~pr[24+r]);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic apply(input logic rm, input logic [2:0] t, input logic c, input logic b,
                       input logic s, input logic [31:0] pr, input logic [31:0] nm);
    string tg;
    logic [15:0] e;
    @(negedge clk);
    in_valid = 1; remap_en = rm; tex = t; cache_b = c; buf_b = b; share_b = s;
    prim_remap = pr; norm_remap = nm;
    e = model(rm, t, c, b, s, pr, nm, tg);
    exp_q.push_back(e);
    tag_q.push_back(tg);
  endtask

  // Monitor: pops one expected item per valid result.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected out_valid", {15'b0, out_valid}, 16'h0);
      end else begin
        check(tag_q.pop_front(), observed(), exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] held;
    rst_n = 0; in_valid = 0; remap_en = 0; tex = 0; cache_b = 0; buf_b = 0; share_b = 0;
    prim_remap = 0; norm_remap = 0;
    repeat (3) @(negedge clk);
    check("R1 reset", {observed()[15:0]}, 16'h0);
    check("R1 reset valid", {15'b0, out_valid}, 16'h0);
    rst_n = 1;

    // Direct scheme: every code, both shareable values.
    for (int i = 0; i < 64; i++)
      apply(1'b0, i[4:2], i[1], i[0], i[5], 32'hFFFF_FFFF, 32'h0);

    // Remap scheme: several remap words, every region, both S, both tex[2:1].
    for (int p = 0; p < 6; p++) begin
      logic [31:0] pr, nm;
      pr = 32'h9E37_79B9 * (p + 1) ^ (32'h0005_2222 << p);
      nm = 32'h7F4A_7C15 * (p + 3);
      if (p == 0) pr = 32'h55AA_EDA6;
      for (int i = 0; i < 32; i++)
        apply(1'b1, {i[4], i[4], i[2]}, i[1], i[0], i[3], pr, nm);
    end
    // All regions Normal with every share-select combination.
    for (int q = 0; q < 4; q++)
      for (int i = 0; i < 16; i++)
        apply(1'b1, {2'b00, i[2]}, i[1], i[0], i[3],
              32'h0F00_AAAA | (32'(q) << 18), 32'h1B6C_E439);

    @(negedge clk);
    in_valid = 0;
    repeat (2) @(negedge clk);
    check("R2 queue drained", {15'b0, exp_q.size() != 0}, 16'h0);

    // R2: idle cycles with scrambled inputs must not disturb the outputs.
    held = observed();
    remap_en = ~remap_en; tex = 3'b101; cache_b = 1; buf_b = 0; share_b = 1;
    prim_remap = 32'h1234_5678; norm_remap = 32'h8765_4321;
    repeat (3) @(negedge clk);
    check("R2 hold", observed(), held);
    check("R2 valid low", {15'b0, out_valid}, 16'h0);
    check("R13 transient/tagged", {14'b0, out_transient, out_tagged}, 16'h0);

    finish_run();
  end

endmodule